// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Status Flags

This block is a clock-master, full-duplex serial port. Software fills a one-byte transmit holding register. The block shifts that byte out least significant bit first and, in the same frame, shifts a byte in from the serial input. The received byte goes to a receive holding register. A programmable divider sets the shift-clock rate. Three status flags drive the software loop: transmit-empty, receive-full and overrun. Writing the transmit register clears transmit-empty, and reading the receive register clears receive-full.

A frame starts only when a byte is waiting in the transmit register, at least one direction is enabled and no overrun is pending. If software refills the transmit register before the current frame ends, the next frame follows with no gap in the clock. If the register is still empty at the boundary, the clock stops high. If a frame completes while the receive register still holds unread data, the new byte is dropped and the overrun flag is set. Both directions then stay frozen until software writes 0 to the flag.

Register addresses: 0 control (bit 0 transmit enable, bit 1 receive enable), 1 divider, 2 status (bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun), 3 transmit data (write), 4 receive data (read). Reads are combinational from the address while the read strobe is high. Side effects of a read take place at the clock edge.

Top module: `syx_top`

## Requirements
- R1: After reset the status register reads 0x01 (only transmit-empty set), the receive data register reads 0x00, and both the shift clock and the serial output are high.
- R2: A write to the transmit data register (address 3) clears status bit 0 (transmit-empty) in the next cycle.
- R3: A read of the receive data register (address 4) clears status bit 1 (receive-full) in the next cycle.
- R4: A frame moves the transmit register into the shifter and sets transmit-empty in the same cycle. It then shifts 8 bits out on the serial output and 8 bits in from the serial input, least significant bit first. When it ends, the received byte is in address 4 and receive-full is set.
- R5: If a frame ends while receive-full is 1, status bit 2 (overrun) is set and the receive data register keeps its old value.
- R6: While overrun is 1, no frame starts. Writing the status register with bit 2 at 0 clears overrun, and pending frames then resume.
- R7: At a frame boundary with transmit-empty at 1, the shift clock stops high until a byte is written.
- R8: The serial output changes only on falling shift-clock edges. Input is sampled on rising edges, and the clock is high whenever no frame is running.
- R9: With divider value N at address 1, the shift-clock period is 2×(N+1) system clocks.
- R10: Writing the status register with bit 2 at 1 leaves overrun unchanged.
- R11: When both enables (control bits 0 and 1) are 0, any running frame stops: the shift clock is high in the next cycle and no further edges occur.
- R12: With transmit enable 0 the serial output stays high during frames. With receive enable 0, frames do not change the receive register or the receive-full flag.
- R13: If the transmit register is refilled before a frame ends, the next frame follows with no gap: every rising shift-clock edge across both frames is one clock period apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sdi | input | 1 | Serial data in, sampled on rising shift-clock edges |
| sdo | output | 1 | Serial data out, changed on falling shift-clock edges |
| sck | output | 1 | Generated shift clock, idles high |

## Verification
The assertions assume that a read or write strobe lasts exactly one cycle. They also assume that software does not write the transmit register while transmit-empty is 0, and that it changes the divider only while no frame is running. The bench drives the bus only through one-cycle tasks and polls transmit-empty before each refill. It writes the divider only between frames, after receive data has been collected or the clock has been seen to stop. The serial input is driven by a slave model just after each falling shift-clock edge, so it is stable long before the block samples it on the following rising edge.

// File: rtl/syx_pkg.sv
package syx_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_DIV  = 3'd1,
    REG_STAT = 3'd2,
    REG_TXD  = 3'd3,
    REG_RXD  = 3'd4
  } reg_sel_e;

  localparam int STAT_TXE = 0;
  localparam int STAT_RXF = 1;
  localparam int STAT_OVR = 2;
  localparam int CTRL_TXEN = 0;
  localparam int CTRL_RXEN = 1;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;
endpackage

// File: rtl/syx_divider.sv
module syx_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // Half period lasts div+1 cycles: the counter wraps when it reaches div.
  function automatic logic at_terminal(input logic [DIV_W-1:0] c, input logic [DIV_W-1:0] d);
    return c == d;
  endfunction

  assign tick = run && at_terminal(cnt, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/syx_engine.sv
module syx_engine
  import syx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  logic              abort,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_en,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              running,
  output logic              frame_start,
  output logic              frame_done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  eng_state_e        state;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-2:0] rx_sh;
  logic              last_bit;
  logic              rise_ev;
  logic              fall_ev;
  logic              boundary;

  assign running  = (state == ENG_RUN);
  assign last_bit = (bit_idx == LAST_BIT);
  assign rise_ev  = running && tick && !sck;
  assign fall_ev  = running && tick && sck;
  assign boundary = fall_ev && last_bit;

  assign frame_start = active && tx_avail && (!running || boundary);
  assign frame_done  = rise_ev && last_bit;
  assign rx_word     = {sdi, rx_sh};
  assign sdo         = (running && tx_en) ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      sck     <= 1'b1;
      bit_idx <= '0;
      tx_sh   <= '1;
      rx_sh   <= '0;
    end else if (abort) begin
      state <= ENG_IDLE;
      sck   <= 1'b1;
    end else if (frame_start) begin
      state   <= ENG_RUN;
      sck     <= 1'b0;
      bit_idx <= '0;
      tx_sh   <= tx_word;
    end else if (rise_ev) begin
      sck   <= 1'b1;
      rx_sh <= rx_word[DATA_W-1:1];
    end else if (boundary) begin
      state <= ENG_IDLE;
    end else if (fall_ev) begin
      sck     <= 1'b0;
      bit_idx <= bit_idx + 1'b1;
      tx_sh   <= {1'b1, tx_sh[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/syx_regfile.sv
module syx_regfile
  import syx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              tx_en,
  output logic              rx_en,
  output logic [DIV_W-1:0]  div,
  output logic [DATA_W-1:0] tx_word,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              ovr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_store,
  output logic              ovr_set
);
  logic wr_ctrl, wr_div, wr_stat, wr_txd, rd_rxd, ovr_clr;

  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_div  = bus_wr && (bus_addr == REG_DIV);
  assign wr_stat = bus_wr && (bus_addr == REG_STAT);
  assign wr_txd  = bus_wr && (bus_addr == REG_TXD);
  assign rd_rxd  = bus_rd && (bus_addr == REG_RXD);

  // A read in the completion cycle counts as servicing the old byte.
  assign rx_store = frame_done && rx_en && (!rx_full || rd_rxd);
  assign ovr_set  = frame_done && rx_en && rx_full && !rd_rxd;
  assign ovr_clr  = wr_stat && !bus_wdata[STAT_OVR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      div     <= DIV_W'(DIV_RST);
      tx_word <= '0;
      rx_data <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_en <= bus_wdata[CTRL_TXEN];
        rx_en <= bus_wdata[CTRL_RXEN];
      end
      if (wr_div)   div     <= bus_wdata[DIV_W-1:0];
      if (wr_txd)   tx_word <= bus_wdata;
      if (rx_store) rx_data <= rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (wr_txd)           tx_empty <= 1'b0;
      else if (frame_start) tx_empty <= 1'b1;
      if (rx_store)         rx_full <= 1'b1;
      else if (rd_rxd)      rx_full <= 1'b0;
      if (ovr_set)          ovr <= 1'b1;
      else if (ovr_clr)     ovr <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        REG_CTRL: begin
          bus_rdata[CTRL_TXEN] = tx_en;
          bus_rdata[CTRL_RXEN] = rx_en;
        end
        REG_DIV:  bus_rdata = DATA_W'(div);
        REG_STAT: begin
          bus_rdata[STAT_TXE] = tx_empty;
          bus_rdata[STAT_RXF] = rx_full;
          bus_rdata[STAT_OVR] = ovr;
        end
        REG_RXD:  bus_rdata = rx_data;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/syx_top.sv
module syx_top #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sdi,
  output logic              sdo,
  output logic              sck
);
  logic              tx_en, rx_en, tx_empty, rx_full, ovr;
  logic              active, abort, tick, running;
  logic              frame_start, frame_done, rx_store, ovr_set;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] tx_word, rx_word, rx_data;

  assign abort  = !(tx_en || rx_en);
  assign active = !abort && !ovr;

  syx_regfile #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_start(frame_start), .frame_done(frame_done), .rx_word(rx_word),
    .tx_en(tx_en), .rx_en(rx_en), .div(div), .tx_word(tx_word),
    .tx_empty(tx_empty), .rx_full(rx_full), .ovr(ovr), .rx_data(rx_data),
    .rx_store(rx_store), .ovr_set(ovr_set)
  );

  syx_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running), .div(div), .tick(tick)
  );

  syx_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(active), .abort(abort),
    .tx_avail(!tx_empty), .tx_word(tx_word), .tx_en(tx_en), .sdi(sdi),
    .sck(sck), .sdo(sdo), .running(running),
    .frame_start(frame_start), .frame_done(frame_done), .rx_word(rx_word)
  );
endmodule

// File: rtl/syx_checker.sv
module syx_checker
  import syx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              sck,
  input logic              sdo,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              ovr,
  input logic              running,
  input logic              frame_start,
  input logic              frame_done,
  input logic [DATA_W-1:0] rx_data
);
  logic wr_txd, rd_rxd, wr_stat;
  assign wr_txd  = bus_wr && (bus_addr == REG_TXD);
  assign rd_rxd  = bus_rd && (bus_addr == REG_RXD);
  assign wr_stat = bus_wr && (bus_addr == REG_STAT);

  AST_TXE_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_txd |=> !tx_empty); // R2
  AST_RXF_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_rxd && !frame_done) |=> !rx_full); // R3
  AST_LOAD_SETS_TXE: assert property (@(posedge clk) disable iff (!rst_n) (frame_start && !wr_txd) |=> tx_empty); // R4
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (frame_done && rx_en && rx_full && !rd_rxd) |=> (ovr && $stable(rx_data))); // R5
  AST_OVR_NO_START: assert property (@(posedge clk) disable iff (!rst_n) ovr |-> !frame_start); // R6
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !running |-> sck); // R8
  AST_SDO_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n) ($rose(sck) && running && $stable(tx_en)) |-> $stable(sdo)); // R8
  AST_OVR_WRITE1_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (ovr && wr_stat && bus_wdata[STAT_OVR]) |=> ovr); // R10
  AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n) (!tx_en && !rx_en) |=> !running); // R11
endmodule

bind syx_top syx_checker #(.DATA_W(DATA_W)) i_syx_checker (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .sck(sck), .sdo(sdo), .tx_en(tx_en), .rx_en(rx_en),
  .tx_empty(tx_empty), .rx_full(rx_full), .ovr(ovr), .running(running),
  .frame_start(frame_start), .frame_done(frame_done), .rx_data(rx_data)
);

// File: tb/test_syx_top.sv
module test_syx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sdi = 1'b0;
  logic       sdo;
  logic       sck;

  int n_chk = 0, n_fail = 0;
  int mon_chk = 0, mon_fail = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] slv_q[$];
  longint     rise_tm[$];

  always #5 clk = ~clk;

  syx_top i_syx_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sdi(sdi), .sdo(sdo), .sck(sck)
  );

  // Monitor: collect serial output on rising edges, compare whole bytes (R4, R8, R12).
  logic [7:0] mon_sh = 8'h00;
  int         mon_bits = 0;
  always @(posedge sck) begin
    if (rst_n) begin
      logic [7:0] e;
      rise_tm.push_back($time);
      mon_sh = {sdo, mon_sh[7:1]};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        mon_chk++;
        if (tx_exp.size() == 0) begin
          mon_fail++;
          $display("FAIL R4: unexpected frame on sdo act=%02h exp=none", mon_sh);
        end else begin
          e = tx_exp.pop_front();
          if (mon_sh !== e) begin
            mon_fail++;
            $display("FAIL R4: sdo byte act=%02h exp=%02h", mon_sh, e);
          end
        end
      end
    end
  end

  // Slave model: present next bit after each falling edge, LSB first.
  logic [7:0] slv_cur = 8'h00;
  int         slv_bit = 0;
  always @(negedge sck) begin
    if (rst_n) begin
      if (slv_bit == 0) slv_cur = (slv_q.size() != 0) ? slv_q.pop_front() : 8'h00;
      sdi = slv_cur[slv_bit];
      slv_bit = (slv_bit + 1) % 8;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic poll(input int bitpos);
    logic [7:0] s;
    s = 8'h00;
    while (!s[bitpos]) rd(3'd2, s);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", (n_chk + mon_chk) - (n_fail + mon_fail), n_chk + mon_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    report();
  end

  initial begin
    logic [7:0] v;
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd2, v); check("R1 status", v, 8'h01);
    rd(3'd4, v); check("R1 rxd", v, 8'h00);
    check("R1 sck", sck, 1); check("R1 sdo", sdo, 1);

    // R2 write clears transmit-empty (block disabled, byte stays pending)
    wr(3'd3, 8'h11);
    rd(3'd2, v); check("R2 txe clear", v[0], 0);

    // R4 / R9 first transfer with divider 2
    tx_exp.push_back(8'h11); slv_q.push_back(8'hE7);
    wr(3'd1, 8'd2);
    wr(3'd0, 8'h03);
    poll(1);
    rd(3'd4, v); check("R4 rx byte", v, 8'hE7);
    rd(3'd2, v); check("R3 rxf clear", v[1], 0);
    check("R9 period div2", rise_tm[rise_tm.size()-1] - rise_tm[rise_tm.size()-2], 60);

    // R9 divider 0
    wr(3'd1, 8'd0);
    tx_exp.push_back(8'hA5); slv_q.push_back(8'h3C);
    wr(3'd3, 8'hA5);
    poll(1);
    rd(3'd4, v); check("R4 rx byte 2", v, 8'h3C);
    check("R9 period div0", rise_tm[rise_tm.size()-1] - rise_tm[rise_tm.size()-2], 20);

    // R7 clock halts high with nothing to send
    snap = rise_tm.size();
    repeat (60) @(negedge clk);
    check("R7 no edges", rise_tm.size(), snap);
    check("R7 sck high", sck, 1);

    // R13 back-to-back with divider 7
    wr(3'd1, 8'd7);
    snap = rise_tm.size();
    tx_exp.push_back(8'h96); tx_exp.push_back(8'h0F);
    slv_q.push_back(8'h5B);  slv_q.push_back(8'hC6);
    wr(3'd3, 8'h96);
    poll(0);
    wr(3'd3, 8'h0F);
    poll(1);
    rd(3'd4, v); check("R13 rx first", v, 8'h5B);
    poll(1);
    rd(3'd4, v); check("R13 rx second", v, 8'hC6);
    check("R13 edge count", rise_tm.size() - snap, 16);
    begin
      int bad = 0;
      for (int i = snap + 1; i < snap + 16; i++)
        if (rise_tm[i] - rise_tm[i-1] != 160) bad++;
      check("R13 gapless", bad, 0);
    end

    // R5 / R6 / R10 overrun with divider 1
    wr(3'd1, 8'd1);
    tx_exp.push_back(8'h01); tx_exp.push_back(8'h02); tx_exp.push_back(8'h03);
    slv_q.push_back(8'h21);  slv_q.push_back(8'h42);  slv_q.push_back(8'h84);
    wr(3'd3, 8'h01);
    poll(0);
    wr(3'd3, 8'h02);
    poll(2);
    rd(3'd2, v); check("R5 status", v, 8'h07);
    wr(3'd3, 8'h03);
    snap = rise_tm.size();
    repeat (60) @(negedge clk);
    check("R6 frozen", rise_tm.size(), snap);
    wr(3'd2, 8'h04);
    rd(3'd2, v); check("R10 write1 ignored", v[2], 1);
    rd(3'd4, v); check("R5 rxd kept", v, 8'h21);
    wr(3'd2, 8'h00);
    poll(1);
    rd(3'd4, v); check("R6 resumed", v, 8'h84);
    rd(3'd2, v); check("R6 ovr cleared", v[2], 0);

    // R12 transmit disabled: sdo high, reception works
    wr(3'd0, 8'h02);
    tx_exp.push_back(8'hFF); slv_q.push_back(8'h81);
    wr(3'd3, 8'h5A);
    poll(1);
    rd(3'd4, v); check("R12 rx only", v, 8'h81);

    // R12 receive disabled: register and flag untouched
    wr(3'd0, 8'h01);
    tx_exp.push_back(8'h77); slv_q.push_back(8'h99);
    snap = rise_tm.size();
    wr(3'd3, 8'h77);
    while (rise_tm.size() < snap + 8) @(negedge clk);
    repeat (10) @(negedge clk);
    rd(3'd2, v); check("R12 no rxf", v, 8'h01);
    rd(3'd4, v); check("R12 rxd kept", v, 8'h81);
    check("R4 all frames seen", tx_exp.size(), 0);

    // R11 disable mid-frame
    wr(3'd1, 8'd7);
    wr(3'd0, 8'h03);
    snap = rise_tm.size();
    wr(3'd3, 8'hFF);
    while (rise_tm.size() < snap + 2) @(negedge clk);
    wr(3'd0, 8'h00);
    check("R11 sck high", sck, 1);
    check("R11 sdo high", sdo, 1);
    snap = rise_tm.size();
    repeat (60) @(negedge clk);
    check("R11 no edges", rise_tm.size(), snap);

    report();
  end
endmodule